// File: doc/BRIEF.md
# Oscillator Source Selector with Warm-up Handover

This block decides which oscillator feeds the system clock path. Two choices exist: an internal ring oscillator, and an external source that is either a crystal (or externally driven clock) or an RC network. Software writes a small control word that holds a ring-select bit and a crystal/RC bit. The block reports a read-only status bit that is 1 while the ring oscillator is the live source. The selected source then continues to the divide stage, which lies outside this block.

Moving onto the ring oscillator takes effect at once. Moving off it is deferred: the ring keeps the system clock while a warm-up counter counts `WARM_CYCLES` pulses of the target external oscillator. That oscillator is presented as a one-cycle `ext_tick` enable in the controller's clock domain. The crystal amplifier is switched off while the ring runs by choice. It is switched on again as soon as ring-select is cleared with the crystal chosen, so its start-up falls inside the warm-up. The crystal/RC bit is write-protected unless ring-select is already set. The power-on reset `por_n` initialises the select bits. The system reset `sys_rst_n` leaves them untouched and only holds an ongoing warm-up count at zero. There is no streaming data path, so every pin is a plain level or strobe.

Top module: `osc_src_select`

## Requirements
- R1: While and after power-on reset, `cfg_rdata` reads 3'b110 (status 1, crystal/RC select 1, ring-select 0), `clk_src` is 0 (ring) and `xamp_en` is 1, and a warm-up toward the crystal is in progress from a count of zero.
- R2: A write (`cfg_we`=1) with bit 0 of `cfg_wdata` set makes the ring the source on the next cycle: status bit 2 reads 1, `clk_src`=0 and `xamp_en`=0.
- R3: A write with bit 0 clear while the ring is selected by choice starts a warm-up from zero. The ring stays the source until the warm-up ends, and a write with bit 0 clear during a warm-up or while external does not restart it.
- R4: The handover to the external source happens on the clock edge that samples the `WARM_CYCLES`-th `ext_tick` of the warm-up. In that same cycle status falls to 0 and `clk_src` becomes 2 for crystal (bit 1 = 1) or 1 for RC (bit 1 = 0).
- R5: A write with bit 0 set during warm-up aborts it, with the ring kept as source. A later clear counts again from zero.
- R6: Bit 1 of `cfg_wdata` is stored only when the stored ring-select (read bit 0) was 1 before the write. Otherwise the crystal/RC select is left unchanged.
- R7: Read layout is bit 0 ring-select, bit 1 crystal/RC select, bit 2 status. Bit 2 of any write is ignored.
- R8: Asserting `sys_rst_n` low leaves ring-select, crystal/RC select and the current source unchanged, and holds a running warm-up count at zero without counting ticks.
- R9: `xamp_en` is 1 exactly when ring-select is clear (warm-up or external) and crystal is chosen. With RC chosen it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | Any other reset, synchronous, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 3 | Control word write value (bit 0 ring-select, bit 1 crystal/RC, bit 2 ignored) |
| ext_tick | input | 1 | One pulse per cycle of the target external oscillator |
| cfg_rdata | output | 3 | Control word read value (bit 2 status) |
| ring_active | output | 1 | Ring oscillator currently supplies the clock |
| clk_src | output | 2 | Live source: 0 ring, 1 RC, 2 crystal |
| xamp_en | output | 1 | Crystal amplifier enable |

## Verification
The properties assume `ext_tick` and `cfg_we` are synchronous single-cycle qualifiers sampled on `clk`. They also assume no write arrives in the same cycle as a system reset whose stability is being checked. The warm-up window property counts ticks itself and so trusts that every `ext_tick` pulse is one oscillator cycle. The stimulus changes inputs only on the falling edge. It issues writes and system-reset pulses in separate cycles wherever the frozen-state rule is examined. It runs with a short warm-up length so that exact tick counts at the handover boundary stay cheap to reach.

// File: rtl/osc_sel_pkg.sv
package osc_sel_pkg;
  // Control word width and field positions
  localparam int CTRL_W   = 3;
  localparam int BIT_RING = 0;
  localparam int BIT_XTAL = 1;
  localparam int BIT_STAT = 2;

  typedef enum logic [1:0] {
    ST_RING = 2'd0,  // ring chosen by software
    ST_WARM = 2'd1,  // ring live, external warming up
    ST_EXT  = 2'd2   // external source live
  } osc_state_e;

  typedef enum logic [1:0] {
    SRC_RING = 2'd0,
    SRC_RC   = 2'd1,
    SRC_XTAL = 2'd2
  } osc_src_e;
endpackage

// File: rtl/osc_sel_regs.sv
module osc_sel_regs
  import osc_sel_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic              ring_sel,
  output logic              xtal_sel,
  output logic              ring_set,
  output logic              ring_clr
);
  // Select bits see only the power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ring_sel <= 1'b0;
      xtal_sel <= 1'b1;
    end else if (we) begin
      ring_sel <= wdata[BIT_RING];
      // Crystal/RC choice is frozen unless the ring is already selected
      if (ring_sel) xtal_sel <= wdata[BIT_XTAL];
    end
  end

  assign ring_set = we &  wdata[BIT_RING];
  assign ring_clr = we & ~wdata[BIT_RING];
endmodule

// File: rtl/osc_sel_warmup.sv
module osc_sel_warmup #(
  parameter int WARM_CYCLES = 65536
) (
  input  logic clk,
  input  logic por_n,
  input  logic clear,  // restart count from zero
  input  logic hold,   // system reset: keep count at zero
  input  logic run,    // warm-up in progress
  input  logic tick,   // one target-oscillator cycle
  output logic done
);
  localparam int CNT_W = (WARM_CYCLES > 1) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WARM_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = run & tick & ~hold & ~clear & (cnt == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cnt <= '0;
    else if (clear || hold)   cnt <= '0;
    else if (done)            cnt <= '0;
    else if (run && tick)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/osc_sel_fsm.sv
module osc_sel_fsm
  import osc_sel_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       ring_set,
  input  logic       ring_clr,
  input  logic       warm_done,
  input  logic       xtal_sel,
  output logic       warm_start,
  output logic       warm_run,
  output logic       ring_active,
  output logic [1:0] clk_src,
  output logic       xamp_en
);
  osc_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RING: if (ring_clr)       state_nx = ST_WARM;
      ST_WARM: if (ring_set)       state_nx = ST_RING;
               else if (warm_done) state_nx = ST_EXT;
      ST_EXT:  if (ring_set)       state_nx = ST_RING;
      default:                     state_nx = ST_WARM;
    endcase
  end

  // Power-on starts a warm-up toward the default external source
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state <= ST_WARM;
    else        state <= state_nx;
  end

  assign warm_start  = (state == ST_RING) & ring_clr;
  assign warm_run    = (state == ST_WARM);
  assign ring_active = (state != ST_EXT);
  assign xamp_en     = (state != ST_RING) & xtal_sel;

  always_comb begin
    if (state != ST_EXT) clk_src = SRC_RING;
    else if (xtal_sel)   clk_src = SRC_XTAL;
    else                 clk_src = SRC_RC;
  end
endmodule

// File: rtl/osc_src_select.sv
module osc_src_select
  import osc_sel_pkg::*;
#(
  parameter int WARM_CYCLES = 65536
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              ext_tick,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              ring_active,
  output logic [1:0]        clk_src,
  output logic              xamp_en
);
  logic ring_sel, xtal_sel, ring_set, ring_clr;
  logic warm_start, warm_run, warm_done;

  osc_sel_regs u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .ring_sel (ring_sel),
    .xtal_sel (xtal_sel),
    .ring_set (ring_set),
    .ring_clr (ring_clr)
  );

  osc_sel_warmup #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk   (clk),
    .por_n (por_n),
    .clear (warm_start),
    .hold  (~sys_rst_n),
    .run   (warm_run),
    .tick  (ext_tick),
    .done  (warm_done)
  );

  osc_sel_fsm u_fsm (
    .clk         (clk),
    .por_n       (por_n),
    .ring_set    (ring_set),
    .ring_clr    (ring_clr),
    .warm_done   (warm_done),
    .xtal_sel    (xtal_sel),
    .warm_start  (warm_start),
    .warm_run    (warm_run),
    .ring_active (ring_active),
    .clk_src     (clk_src),
    .xamp_en     (xamp_en)
  );

  always_comb begin
    cfg_rdata           = '0;
    cfg_rdata[BIT_RING] = ring_sel;
    cfg_rdata[BIT_XTAL] = xtal_sel;
    cfg_rdata[BIT_STAT] = ring_active;
  end
endmodule

// File: rtl/osc_src_select_chk.sv
module osc_src_select_chk #(
  parameter int WARM_CYCLES = 65536
) (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst_n,
  input logic       cfg_we,
  input logic [2:0] cfg_wdata,
  input logic       ext_tick,
  input logic [2:0] cfg_rdata,
  input logic       ring_active,
  input logic [1:0] clk_src,
  input logic       xamp_en
);
  // Independent count of ticks seen while warming up
  int unsigned wcnt;
  logic        warming;
  assign warming = ring_active & ~cfg_rdata[0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      wcnt <= 0;
    else if (!warming || !sys_rst_n) wcnt <= 0;
    else if (ext_tick)               wcnt <= wcnt + 1;
  end

  // R2
  ring_now_chk: assert property (@(posedge clk) disable iff (!por_n)
    cfg_we && cfg_wdata[0] |=> ring_active && !xamp_en && cfg_rdata[0]);

  // R6
  xtal_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
    cfg_we && !cfg_rdata[0] |=> $stable(cfg_rdata[1]));

  // R3
  ext_needs_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    !ring_active |-> !cfg_rdata[0]);

  // R4
  handover_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(ring_active) |-> $past(ext_tick) && ($past(wcnt) == WARM_CYCLES - 1));

  // R4
  src_code_chk: assert property (@(posedge clk) disable iff (!por_n)
    (ring_active && clk_src == 2'd0) ||
    (!ring_active && clk_src == (cfg_rdata[1] ? 2'd2 : 2'd1)));

  // R9
  amp_rule_chk: assert property (@(posedge clk) disable iff (!por_n)
    xamp_en |-> cfg_rdata[1] && !cfg_rdata[0]);

  // R8
  sysrst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n && !cfg_we |=> cfg_rdata[1:0] == $past(cfg_rdata[1:0]));
endmodule

bind osc_src_select osc_src_select_chk #(.WARM_CYCLES(WARM_CYCLES)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .sys_rst_n   (sys_rst_n),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .ext_tick    (ext_tick),
  .cfg_rdata   (cfg_rdata),
  .ring_active (ring_active),
  .clk_src     (clk_src),
  .xamp_en     (xamp_en)
);

// File: tb/test_osc_src_select.sv
`timescale 1ns/1ps
module test_osc_src_select;
  localparam int WARM = 8;
  localparam int NV   = 35;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_rst_n = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_wdata = 3'b000;
  logic       ext_tick = 1'b0;
  logic [2:0] cfg_rdata;
  logic       ring_active;
  logic [1:0] clk_src;
  logic       xamp_en;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  osc_src_select #(.WARM_CYCLES(WARM)) i_osc_src_select (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .ext_tick(ext_tick), .cfg_rdata(cfg_rdata),
    .ring_active(ring_active), .clk_src(clk_src), .xamp_en(xamp_en)
  );

  // {tag, we, wdata, tick, sys_rst_n, exp rdata, exp src, exp amp}
  localparam logic [27:0] VECS [0:NV-1] = '{
    {"R1", 1'b0, 3'b000, 1'b0, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R6", 1'b1, 3'b000, 1'b0, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R2", 1'b1, 3'b011, 1'b0, 1'b1, 3'b111, 2'd0, 1'b0},
    {"R6", 1'b1, 3'b001, 1'b0, 1'b1, 3'b101, 2'd0, 1'b0},
    {"R3", 1'b1, 3'b000, 1'b0, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b100, 2'd0, 1'b0},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b000, 2'd1, 1'b0},
    {"R7", 1'b1, 3'b100, 1'b0, 1'b1, 3'b000, 2'd1, 1'b0},
    {"R6", 1'b1, 3'b011, 1'b0, 1'b1, 3'b101, 2'd0, 1'b0},
    {"R6", 1'b1, 3'b011, 1'b0, 1'b1, 3'b111, 2'd0, 1'b0},
    {"R9", 1'b1, 3'b010, 1'b0, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R3", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R3", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R3", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R5", 1'b1, 3'b011, 1'b1, 1'b1, 3'b111, 2'd0, 1'b0},
    {"R5", 1'b1, 3'b010, 1'b0, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R5", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R5", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R5", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b0, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b1, 1'b1, 3'b110, 2'd0, 1'b1},
    {"R4", 1'b0, 3'b000, 1'b1, 1'b1, 3'b010, 2'd2, 1'b1},
    {"R8", 1'b0, 3'b000, 1'b0, 1'b0, 3'b010, 2'd2, 1'b1}
  };

  task automatic check(input string tag, input logic [2:0] erd,
                       input logic [1:0] esrc, input logic eamp);
    n_run++;
    if (cfg_rdata !== erd || clk_src !== esrc || xamp_en !== eamp) begin
      n_fail++;
      $display("FAIL %s: rdata=%b src=%0d amp=%b expected rdata=%b src=%0d amp=%b",
               tag, cfg_rdata, clk_src, xamp_en, erd, esrc, eamp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic we, input logic [2:0] wd,
                      input logic tick, input logic srst);
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; ext_tick = tick; sys_rst_n = srst;
    @(posedge clk);
    #1;
    cfg_we = 1'b0; ext_tick = 1'b0; sys_rst_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", 3'b110, 2'd0, 1'b1);  // values during power-on reset
    @(negedge clk) por_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i][11], VECS[i][10:8], VECS[i][7], VECS[i][6]);
      check(string'(VECS[i][27:12]), VECS[i][5:3], VECS[i][2:1], VECS[i][0]);
    end

    // R1: power-on reset from the crystal-live state restores defaults
    @(negedge clk) por_n = 1'b0;
    #1 check("R1", 3'b110, 2'd0, 1'b1);
    @(negedge clk) por_n = 1'b1;
    @(posedge clk); #1 check("R1", 3'b110, 2'd0, 1'b1);

    // R8: system reset keeps a ring/RC selection
    step(1'b1, 3'b011, 1'b0, 1'b1);
    step(1'b1, 3'b001, 1'b0, 1'b1);
    check("R6", 3'b101, 2'd0, 1'b0);
    step(1'b0, 3'b000, 1'b0, 1'b0);
    check("R8", 3'b101, 2'd0, 1'b0);

    // R9: RC warm-up and handover never enable the amplifier
    step(1'b1, 3'b000, 1'b0, 1'b1);
    check("R9", 3'b100, 2'd0, 1'b0);
    for (int k = 0; k < WARM - 1; k++) step(1'b0, 3'b000, 1'b1, 1'b1);
    check("R4", 3'b100, 2'd0, 1'b0);
    step(1'b0, 3'b000, 1'b1, 1'b1);
    check("R9", 3'b000, 2'd1, 1'b0);

    // R3: clearing again while external does not restart anything
    step(1'b1, 3'b000, 1'b0, 1'b1);
    check("R3", 3'b000, 2'd1, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule